// File: doc/BRIEF.md
# Receive Packet Descriptor Queue

This block keeps a first-in-first-out list of one-byte descriptors, one for each packet that a receive engine has finished writing into a paged receive buffer. Each descriptor says where the packet starts in the buffer and how many pages it fills. A processor walks the packets in arrival order by reading a byte-wide data port repeatedly. Every read removes the oldest descriptor.

The receive engine pulses a push strobe with the start page and page count once a good packet is fully stored. When the descriptor is accepted, the block pulses a strobe that tells buffer logic to write the packet's status word into its first page. It also raises a receive interrupt, which stays high until the processor clears it. The number of queued descriptors, empty and full indications, and a sticky overflow flag are available as outputs.

Top module: `rx_desc_queue`

## Requirements
- R1: A descriptor read back places the page count in bits 7..5 and the start page in bits 4..0, and descriptors come out in the order they were pushed. The data port shows the oldest descriptor combinationally during the cycle in which the read strobe is high.
- R2: Each cycle with the read strobe high removes one descriptor. A read while the queue is empty shows 0x00 and leaves the count at 0.
- R3: The queue holds at most 31 descriptors. A push while 31 are held and no read happens in that cycle is discarded, and the overflow output then goes high and stays high until reset.
- R4: The count output equals the number of held descriptors (0 to 31), and the empty output is high exactly when the count is 0. After reset the count is 0, empty is high, and interrupt, overflow and status strobe are low.
- R5: An accepted push sets the interrupt output on the next cycle. The interrupt stays set until a cycle with the clear input high and no accepted push. A push in the same cycle as a clear leaves it set.
- R6: The status-write strobe is high for exactly the one cycle that follows each accepted push, and it is low otherwise.
- R7: A push and a read in the same cycle while 31 descriptors are held both take effect. The count stays 31 and overflow is not set.
- R8: A push and a read in the same cycle while the queue is empty store the new descriptor, show 0x00 on the data port, and leave the count at 1.
- R9: The full output is high exactly when the count is 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push strobe from the receive engine |
| push_page_i | input | 5 | Start page of the stored packet |
| push_npages_i | input | 3 | Number of pages the packet occupies |
| rd_i | input | 1 | Processor read strobe (pops one descriptor) |
| rd_data_o | output | 8 | Oldest descriptor, or 0x00 when empty |
| irq_clr_i | input | 1 | Writes 1 to clear the interrupt flag |
| irq_o | output | 1 | Receive interrupt flag |
| status_wr_o | output | 1 | Request to write the packet status word |
| count_o | output | 5 | Number of queued descriptors |
| empty_o | output | 1 | Queue is empty |
| full_o | output | 1 | Queue holds 31 descriptors |
| overflow_o | output | 1 | Sticky flag: a push was discarded |

## Verification
A push from the receive engine and a read from the processor can fall in the same cycle. So can a push and an interrupt clear. The bench forces these collisions deliberately at the two edges of occupancy: a push with a read when 31 descriptors are held, and a push with a read when the queue is empty. It also issues a push together with a clear. It then runs a long pseudo-random stream in which all three strobes overlap freely. Each cycle is judged against an arithmetic reference queue in the bench, which decides acceptance, drops, popped data, the count and the flag states from the pre-edge occupancy.

// File: rtl/rdq_pkg.sv
package rdq_pkg;
  localparam int PAGE_W = 5;
  localparam int NPG_W  = 3;
  localparam int ENT_W  = PAGE_W + NPG_W;

  // bit order matters: page count sits above the start page
  typedef struct packed {
    logic [NPG_W-1:0]  npages;
    logic [PAGE_W-1:0] page;
  } rdq_entry_t;
endpackage

// File: rtl/rdq_ctrl.sv
module rdq_ctrl #(
  parameter int DEPTH = 31,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             rd_i,
  output logic             wr_en_o,
  output logic             rd_en_o,
  output logic [PTR_W-1:0] wptr_o,
  output logic [PTR_W-1:0] rptr_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  // a pop in the same cycle frees a slot for the push
  assign rd_en_o = rd_i && !empty_o;
  assign wr_en_o = push_i && (!full_o || rd_en_o);

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (wr_en_o) wptr_d = ptr_inc(wptr_q);
    if (rd_en_o) rptr_d = ptr_inc(rptr_q);
    case ({wr_en_o, rd_en_o})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_en_o) wptr_q <= wptr_d;
      if (rd_en_o) rptr_q <= rptr_d;
      if (wr_en_o != rd_en_o) cnt_q <= cnt_d;
    end
  end

  assign wptr_o  = wptr_q;
  assign rptr_o  = rptr_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/rdq_store.sv
module rdq_store
  import rdq_pkg::*;
#(
  parameter int DEPTH = 31,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wptr_i,
  input  rdq_entry_t       wdata_i,
  input  logic [PTR_W-1:0] rptr_i,
  output rdq_entry_t       rdata_o
);
  rdq_entry_t slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en_i && (wptr_i == PTR_W'(g))) slot_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rptr_i == PTR_W'(i)) rdata_o = slot_q[i];
    end
  end
endmodule

// File: rtl/rdq_flags.sv
module rdq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  logic accept_i,
  input  logic clr_i,
  output logic irq_o,
  output logic ovf_o,
  output logic stat_o
);
  logic irq_q, irq_d, ovf_q, ovf_d, stat_q;

  always_comb begin
    irq_d = irq_q;
    if (accept_i)   irq_d = 1'b1;
    else if (clr_i) irq_d = 1'b0;
    ovf_d = ovf_q | (push_i & ~accept_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      ovf_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (accept_i || clr_i) irq_q <= irq_d;
      if (push_i)            ovf_q <= ovf_d;
      stat_q <= accept_i;
    end
  end

  assign irq_o  = irq_q;
  assign ovf_o  = ovf_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/rx_desc_queue.sv
module rx_desc_queue
  import rdq_pkg::*;
#(
  parameter int DEPTH = 31,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [PAGE_W-1:0] push_page_i,
  input  logic [NPG_W-1:0]  push_npages_i,
  input  logic              rd_i,
  output logic [ENT_W-1:0]  rd_data_o,
  input  logic              irq_clr_i,
  output logic              irq_o,
  output logic              status_wr_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              overflow_o
);
  logic             wr_en, rd_en;
  logic [PTR_W-1:0] wptr, rptr;
  rdq_entry_t       wdata, rdata;

  assign wdata.npages = push_npages_i;
  assign wdata.page   = push_page_i;

  rdq_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .rd_i(rd_i),
    .wr_en_o(wr_en), .rd_en_o(rd_en), .wptr_o(wptr), .rptr_o(rptr),
    .count_o(count_o), .empty_o(empty_o), .full_o(full_o)
  );

  rdq_store #(.DEPTH(DEPTH)) i_store (
    .clk(clk), .wr_en_i(wr_en), .wptr_i(wptr), .wdata_i(wdata),
    .rptr_i(rptr), .rdata_o(rdata)
  );

  rdq_flags i_flags (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .accept_i(wr_en),
    .clr_i(irq_clr_i), .irq_o(irq_o), .ovf_o(overflow_o), .stat_o(status_wr_o)
  );

  assign rd_data_o = empty_o ? '0 : rdata;
endmodule

// File: rtl/rdq_chk.sv
module rdq_chk #(
  parameter int DEPTH = 31,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic          rd_i,
  input logic          irq_clr_i,
  input logic [7:0]    rd_data_o,
  input logic [CW-1:0] count_o,
  input logic          empty_o,
  input logic          full_o,
  input logic          irq_o,
  input logic          overflow_o,
  input logic          status_wr_o
);
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(DEPTH));

  p_empty_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> rd_data_o == 8'h00);

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + CW'(1))
             || (count_o == $past(count_o) - CW'(1)));

  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o);

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  p_drop_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !rd_i) |=> overflow_o && full_o);

  p_status_after_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !full_o) |=> status_wr_o && irq_o);

  p_full_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && rd_i && full_o && !overflow_o) |=> full_o && !overflow_o);
endmodule

bind rx_desc_queue rdq_chk #(.DEPTH(DEPTH)) i_chk (.*);

// File: tb/test_rx_desc_queue.sv
module test_rx_desc_queue;
  localparam int DEPTH = 31;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       push_i, rd_i, irq_clr_i;
  logic [4:0] push_page_i;
  logic [2:0] push_npages_i;
  logic [7:0] rd_data_o;
  logic       irq_o, status_wr_o, empty_o, full_o, overflow_o;
  logic [4:0] count_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] mq[$];
  bit m_irq, m_ovf, m_stat;

  always #5 clk = ~clk;

  rx_desc_queue i_rx_desc_queue (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: inputs driven at negedge, results checked at the next negedge
  task automatic cyc(input bit p, input logic [4:0] pg, input logic [2:0] np,
                     input bit r, input bit c);
    bit do_rd, do_wr;
    push_i = p; push_page_i = pg; push_npages_i = np; rd_i = r; irq_clr_i = c;
    #1;
    do_rd = r && (mq.size() > 0);
    do_wr = p && (mq.size() < DEPTH || do_rd);
    if (r) chk(do_rd ? "R1 data" : "R2 empty read", int'(rd_data_o),
               do_rd ? int'(mq[0]) : 0);
    @(posedge clk);
    if (do_rd) void'(mq.pop_front());
    if (do_wr) mq.push_back({np, pg});
    if (do_wr) m_irq = 1'b1; else if (c) m_irq = 1'b0;
    if (p && !do_wr) m_ovf = 1'b1;
    m_stat = do_wr;
    @(negedge clk);
    chk("R4 count", int'(count_o), mq.size());
    chk("R4 empty", int'(empty_o), int'(mq.size() == 0));
    chk("R9 full", int'(full_o), int'(mq.size() == DEPTH));
    chk("R5 irq", int'(irq_o), int'(m_irq));
    chk("R3 overflow", int'(overflow_o), int'(m_ovf));
    chk("R6 status", int'(status_wr_o), int'(m_stat));
    push_i = 0; rd_i = 0; irq_clr_i = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 0; push_i = 0; rd_i = 0; irq_clr_i = 0;
    push_page_i = '0; push_npages_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R4 reset state
    chk("R4 reset count", int'(count_o), 0);
    chk("R4 reset empty", int'(empty_o), 1);
    chk("R4 reset irq", int'(irq_o), 0);
    chk("R4 reset ovf", int'(overflow_o), 0);
    chk("R6 reset status", int'(status_wr_o), 0);
    chk("R2 reset data", int'(rd_data_o), 0);
    // R2 read while empty
    cyc(0, 0, 0, 1, 0);
    // R1 field layout: single push, inspect bits
    cyc(1, 5'd21, 3'd6, 0, 0);
    chk("R1 npages field", int'(rd_data_o[7:5]), 6);
    chk("R1 page field", int'(rd_data_o[4:0]), 21);
    cyc(0, 0, 0, 1, 1);
    // R3 fill all 31 slots with distinct patterns
    for (int k = 0; k < DEPTH; k++) cyc(1, 5'((k * 7 + 3) % 32), 3'(k % 8), 0, 0);
    chk("R3 full count", int'(count_o), 31);
    // R7 push and read together while full
    cyc(1, 5'd30, 3'd1, 1, 0);
    chk("R7 count kept", int'(count_o), 31);
    chk("R7 no overflow", int'(overflow_o), 0);
    // R3 dropped push while full
    cyc(1, 5'd9, 3'd2, 0, 0);
    chk("R3 overflow set", int'(overflow_o), 1);
    // R5 push while irq set and clear at the same time keeps it set
    cyc(0, 0, 0, 1, 0);
    cyc(1, 5'd4, 3'd4, 0, 1);
    chk("R5 push beats clear", int'(irq_o), 1);
    cyc(0, 0, 0, 0, 1);
    chk("R5 cleared", int'(irq_o), 0);
    // R1 drain in order
    for (int k = 0; k < DEPTH + 2; k++) cyc(0, 0, 0, 1, 0);
    // R8 push and read together while empty
    cyc(1, 5'd17, 3'd3, 1, 0);
    chk("R8 count one", int'(count_o), 1);
    chk("R8 stored", int'(rd_data_o), int'({3'd3, 5'd17}));
    // free-running mixed stream
    lfsr = 16'hACE1;
    for (int k = 0; k < 6000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] | (k % 600 < 200 ? lfsr[1] : 1'b0), lfsr[6:2], lfsr[9:7],
          lfsr[11] & (k % 600 >= 100 || lfsr[12]), lfsr[13] & lfsr[14]);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule